// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block keeps a 32-bit up-counter and a 32-bit match register and raises a timer interrupt when the counter arrives at the match value. Software reaches both registers through a small register port. A single write strobe with a one-bit register select loads either register. A separate combinational read select returns either value, sign-extended to 64 bits. The counter does not advance on every core clock. A prescaler steps it once every `rate_div` core clocks, so one timer tick can be stretched over many core cycles.

The interrupt is sticky. Once the counter steps onto the match value, `timer_irq` stays high until software writes the match register. There is no other way to acknowledge it. Each match-register write also produces a one-cycle `irq_refresh` pulse, which the surrounding interrupt logic uses to re-evaluate its pending flags. A separate free-running core-clock tick counter is exported for a neighbouring unit to use as a cheap pseudo-random source.

Top module: `cmp_timer`

## Requirements
- R1: While `rst` is high, the count and match registers read as zero, `timer_irq` and `irq_refresh` are low, and `tick_val` is zero.
- R2: With an effective divisor D, the count register increments by exactly one every D core clocks. The first increment comes D rising edges after a count write.
- R3: A `rate_div` value of 0 behaves exactly as a value of 1: the count increments on every core clock.
- R4: Writing the count register (`wr_sel` = 0) loads `wr_data` on that edge and restarts the prescaler. Counting then continues upward from the loaded value.
- R5: The count wraps from 0xFFFFFFFF to 0x00000000.
- R6: `timer_irq` rises on the same edge on which the count steps to a value equal to the match register. It is therefore high in the first cycle in which the count reads equal to the match value.
- R7: Once set, `timer_irq` stays high while the count keeps advancing past the match value, until the match register is written.
- R8: Writing the match register (`wr_sel` = 1) clears `timer_irq` on that edge. `irq_refresh` is high for exactly the one cycle that follows the write edge.
- R9: `rd_data` returns the register chosen by `rd_sel` (0 = count, 1 = match) with bit 31 copied into bits 63:32.
- R10: Loading the count with a value equal to the match value does not set `timer_irq`. Only a prescaler step onto the match value sets it.
- R11: `tick_val` increments by one on every core clock after reset, independent of the divisor and of register writes.
- R12: Rewriting the match register with its current value while the interrupt is pending still clears the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_div | input | 8 | Core clocks per count step; 0 is treated as 1 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = count, 1 = match |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | Read source: 0 = count, 1 = match |
| rd_data | output | 64 | Selected register, sign-extended from bit 31 |
| timer_irq | output | 1 | Sticky timer interrupt |
| irq_refresh | output | 1 | One-cycle pulse after each match-register write |
| tick_val | output | 16 | Free-running core-clock tick value |

## Verification
The bench checks the step rate at several divisors, including the zero divisor. A prescaler that is off by one, or that misses its restart on a count write, shows up as an increment one cycle early or late. It targets the exact cycle in which the interrupt rises. A comparator that uses the current count instead of the next count would raise the interrupt one step too late. It also checks that loading the count directly onto the match value does not raise the interrupt. Further scenarios cover the wrap at 2^32 and the upper-word sign copy on reads of negative and positive values. The last one rewrites an unchanged match value to acknowledge a pending interrupt, which a design that clears only on a value change would fail.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int unsigned CNT_W = 32;
    localparam int unsigned RD_W  = 2 * CNT_W;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_MATCH = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        reg_sel_e         sel;
        logic [CNT_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic load_count;
        logic load_match;
    } wr_dec_t;

    function automatic logic [RD_W-1:0] widen_signed(input logic [CNT_W-1:0] v);
        return {{(RD_W - CNT_W){v[CNT_W-1]}}, v};
    endfunction

    function automatic wr_dec_t decode_wr(input wr_req_t r);
        wr_dec_t d;
        d.load_count = r.en && (r.sel == SEL_COUNT);
        d.load_match = r.en && (r.sel == SEL_MATCH);
        return d;
    endfunction

endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             step
);
    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] phase_q;

    always_comb begin
        eff_div = (div == '0) ? DIV_W'(1) : div;
        step    = (phase_q >= (eff_div - DIV_W'(1))) && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         advance
);
    always_comb begin
        advance = step && !load;
        if (load) begin
            cnt_d = load_val;
        end else if (advance) begin
            cnt_d = cnt_q + W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    input  logic [W-1:0] cnt_d,
    output logic [W-1:0] match_q,
    output logic         irq_q,
    output logic         refresh_q
);
    logic [W-1:0] match_d;
    logic         hit;
    logic         irq_d;

    always_comb begin
        match_d = load ? load_val : match_q;
        hit     = advance && (cnt_d == match_d);
        irq_d   = (irq_q && !load) || hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q   <= '0;
            irq_q     <= 1'b0;
            refresh_q <= 1'b0;
        end else begin
            match_q   <= match_d;
            irq_q     <= irq_d;
            refresh_q <= load;
        end
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_sel,
    output logic [RD_W-1:0]   rd_data,
    output logic              timer_irq,
    output logic              irq_refresh,
    output logic [TICK_W-1:0] tick_val
);
    wr_req_t          req;
    wr_dec_t          dec;
    logic             step;
    logic             advance;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] match_q;
    logic [TICK_W-1:0] tick_q;

    always_comb begin
        req.en   = wr_en;
        req.sel  = reg_sel_e'(wr_sel);
        req.data = wr_data;
        dec      = decode_wr(req);
    end

    cmp_timer_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .div     (rate_div),
        .restart (dec.load_count),
        .step    (step)
    );

    cmp_timer_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (dec.load_count),
        .load_val (req.data),
        .step     (step),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .advance  (advance)
    );

    cmp_timer_match #(.W(CNT_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .load      (dec.load_match),
        .load_val  (req.data),
        .advance   (advance),
        .cnt_d     (cnt_d),
        .match_q   (match_q),
        .irq_q     (timer_irq),
        .refresh_q (irq_refresh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + TICK_W'(1);
        end
    end

    always_comb begin
        tick_val = tick_q;
        rd_data  = widen_signed((reg_sel_e'(rd_sel) == SEL_MATCH) ? match_q : cnt_q);
    end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int unsigned W      = 32,
    parameter int unsigned TICK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [W-1:0]      wr_data,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      cmpv,
    input logic              irq,
    input logic              refresh,
    input logic [TICK_W-1:0] tick,
    input logic [2*W-1:0]    rd_data
);
    a_r2_step_or_load: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !wr_sel) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + W'(1)));

    a_r6_rise_on_match: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt == cmpv));

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && wr_sel)) |=> irq);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && (wr_data != cnt + W'(1))) |=> !irq);

    a_r8_refresh: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> refresh);

    a_r9_sign_copy: assert property (@(posedge clk) disable iff (rst)
        rd_data[2*W-1:W] == {W{rd_data[W-1]}});

    a_r10_load_no_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !irq) |=> !irq);

    a_r11_tick: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tick == $past(tick) + TICK_W'(1));
endmodule

bind cmp_timer cmp_timer_chk #(.W(cmp_timer_pkg::CNT_W), .TICK_W(TICK_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cnt     (cnt_q),
    .cmpv    (match_q),
    .irq     (timer_irq),
    .refresh (irq_refresh),
    .tick    (tick_val),
    .rd_data (rd_data)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rate_div = 8'd0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data;
    logic        timer_irq;
    logic        irq_refresh;
    logic [15:0] tick_val;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmp_timer u_dut (
        .clk(clk), .rst(rst), .rate_div(rate_div), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .timer_irq(timer_irq),
        .irq_refresh(irq_refresh), .tick_val(tick_val)
    );

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [63:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        @(negedge clk);
        rd(1'b0, v); chk(v == 64'd0, "R1 count", v, 0);
        rd(1'b1, v); chk(v == 64'd0, "R1 match", v, 0);
        chk(!timer_irq && !irq_refresh, "R1 irq", {timer_irq, irq_refresh}, 0);
        chk(tick_val == 16'd0, "R1 tick", tick_val, 0);
    endtask

    task automatic t_rate(input logic [7:0] d, input string req);
        logic [63:0] v;
        int eff;
        eff = (d == 0) ? 1 : int'(d);
        rate_div = d;
        wr(1'b1, 32'h7000_0000);
        wr(1'b0, 32'd100);
        for (int k = 0; k <= 3 * eff; k++) begin
            rd(1'b0, v);
            chk(v == 64'(100 + k / eff), req, v, 64'(100 + k / eff));
            @(negedge clk);
        end
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        rate_div = 8'd1;
        wr(1'b1, 32'h0000_0010);
        wr(1'b0, 32'hFFFF_FFFE);
        rd(1'b0, v); chk(v == sx(32'hFFFF_FFFE), "R9 negative read", v, sx(32'hFFFF_FFFE));
        rd(1'b1, v); chk(v == 64'h10, "R9 positive read", v, 64'h10);
        @(negedge clk); @(negedge clk);
        rd(1'b0, v); chk(v == 64'd0, "R5 wrap", v, 0);
    endtask

    task automatic t_irq();
        logic [63:0] v;
        rate_div = 8'd2;
        wr(1'b1, 32'd50);
        chk(irq_refresh == 1'b1, "R8 refresh pulse", irq_refresh, 1);
        wr(1'b0, 32'd47);
        chk(irq_refresh == 1'b0, "R8 refresh one cycle", irq_refresh, 0);
        repeat (5) @(negedge clk);
        rd(1'b0, v);
        chk(v == 64'd49 && !timer_irq, "R6 not early", {timer_irq, v[31:0]}, 49);
        @(negedge clk);
        rd(1'b0, v);
        chk(v == 64'd50 && timer_irq, "R6 rise on match", {timer_irq, v[31:0]}, {1'b1, 32'd50});
        repeat (4) @(negedge clk);
        chk(timer_irq == 1'b1, "R7 sticky", timer_irq, 1);
        wr(1'b1, 32'd50);
        chk(timer_irq == 1'b0, "R12 same value clears", timer_irq, 0);
        repeat (4) @(negedge clk);
        chk(timer_irq == 1'b0, "R12 stays clear", timer_irq, 0);
        wr(1'b1, 32'd59);
        repeat (6) @(negedge clk);
        chk(timer_irq == 1'b1, "R6 second match", timer_irq, 1);
        wr(1'b1, 32'd500);
        chk(timer_irq == 1'b0, "R8 clear", timer_irq, 0);
    endtask

    task automatic t_load_equal();
        logic [63:0] v;
        rate_div = 8'd4;
        wr(1'b1, 32'd300);
        wr(1'b0, 32'd300);
        for (int k = 0; k < 4; k++) begin
            chk(timer_irq == 1'b0, "R10 load equal", timer_irq, 0);
            @(negedge clk);
        end
        rd(1'b0, v);
        chk(v == 64'd301 && !timer_irq, "R10 after step", {timer_irq, v[31:0]}, 301);
    endtask

    task automatic t_tick();
        logic [15:0] a;
        a = tick_val;
        repeat (7) @(negedge clk);
        chk(tick_val == a + 16'd7, "R11 tick", tick_val, a + 16'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_rate(8'd1, "R2 div1");
        t_rate(8'd3, "R2 div3");
        t_rate(8'd5, "R4 div5 restart");
        t_rate(8'd0, "R3 div0");
        t_wrap();
        t_irq();
        t_load_equal();
        t_tick();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule